// File: doc/BRIEF.md
# Bus-Controller Condition Flag Bank

This block holds the sixteen condition codes of a bus-controller sequencer in one condition space. The upper eight codes reflect the outcome of the most recent message and are loaded together when message execution reports completion. The lower eight codes are general-purpose flags. Three sources can write them, and each source has different rights.

The host writes the flags with a pair of masks: one to set and one to clear. The sequencer's flag instruction carries the same two masks packed into its 16-bit parameter. The two timer-compare instructions can only set or clear the two lowest flags. The host reads all sixteen codes directly. The sequencer's condition evaluator selects one code, and may invert it, to decide whether a conditional instruction runs.

Every pin is a plain control or status signal. Each write source is a single-cycle strobe that is always accepted, so there is no valid/ready handshake and no back-pressure.

Top module: `cond_flag_bank`

## Requirements
- R1: While reset is asserted, all sixteen condition codes read 0.
- R2: A host write (host_wr_en high) acts on each flag GPi using bits i of host_set_mask and host_clr_mask. Set only drives the flag to 1, clear only drives it to 0, both together toggle it, and neither leaves it unchanged.
- R3: A flag instruction (flg_en high) takes its set mask from flg_param[15:8] and its clear mask from flg_param[7:0]. Bit i of each byte acts on GPi with the same set/clear/toggle rule as R2.
- R4: A timer compare (tcmp_en high) acts on GP0 through tcmp_set[0]/tcmp_clr[0] and on GP1 through tcmp_set[1]/tcmp_clr[1]. Set takes priority when both bits are high. GP2 to GP7 never change because of a timer compare.
- R5: When several sources write in the same cycle, they are applied in a fixed order: the flag instruction first, then the timer compare, then the host masks on top of the result.
- R6: A msg_done pulse loads msg_result bit i into condition code 8+i. Without msg_done, codes 8 to 15 hold their values.
- R7: cond_codes presents GP0 to GP7 on bits 7:0 and the message codes on bits 15:8. An update appears there in the cycle after the write.
- R8: cond_true equals condition code number cond_sel, inverted when cond_invert is 1. This path is combinational from cond_sel and cond_invert.
- R9: Flag writes never change codes 8 to 15, and msg_done never changes GP0 to GP7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host flag write strobe |
| host_set_mask | input | 8 | Host set mask, bit i for GPi |
| host_clr_mask | input | 8 | Host clear mask, bit i for GPi |
| flg_en | input | 1 | Flag instruction strobe |
| flg_param | input | 16 | Flag instruction parameter: set mask in [15:8], clear mask in [7:0] |
| tcmp_en | input | 1 | Timer compare strobe |
| tcmp_set | input | 2 | Timer compare set bits for GP1..GP0 |
| tcmp_clr | input | 2 | Timer compare clear bits for GP1..GP0 |
| msg_done | input | 1 | Message completion strobe |
| msg_result | input | 8 | Result codes for codes 8..15 |
| cond_sel | input | 4 | Code index for the condition evaluator |
| cond_invert | input | 1 | Invert the selected code |
| cond_true | output | 1 | Selected code after optional inversion |
| cond_codes | output | 16 | Read-only view of all sixteen codes |

## Verification
The hardest situation to reach is all three flag writers hitting overlapping bits in one cycle, where only the stated order (instruction, then timer, then host) gives the right answer. The stimulus first builds a known flag pattern with single-source writes. It then fires all three strobes in the same cycle with deliberately conflicting masks on GP0, GP1 and GP7. Each resulting bit separates a correct ordering from a swapped one.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;
  // One flag bit under a set/clear mask pair: set-only -> 1, clear-only -> 0,
  // both -> toggle, neither -> keep.
  function automatic logic mask_update(input logic cur, input logic s, input logic c);
    logic r;
    case ({s, c})
      2'b10:   r = 1'b1;
      2'b01:   r = 1'b0;
      2'b11:   r = ~cur;
      default: r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gp_flag_reg.sv
module gp_flag_reg
  import cond_flag_pkg::*;
#(
  parameter int NUM_GP  = 8,
  parameter int NUM_TMR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_en,
  input  logic [NUM_GP-1:0] seq_set,
  input  logic [NUM_GP-1:0] seq_clr,
  input  logic              tmr_en,
  input  logic [NUM_TMR-1:0] tmr_set,
  input  logic [NUM_TMR-1:0] tmr_clr,
  input  logic              host_en,
  input  logic [NUM_GP-1:0] host_set,
  input  logic [NUM_GP-1:0] host_clr,
  output logic [NUM_GP-1:0] flags
);
  logic [NUM_GP-1:0] after_seq, after_tmr, nxt;

  for (genvar i = 0; i < NUM_GP; i++) begin : g_bit
    assign after_seq[i] = seq_en ? mask_update(flags[i], seq_set[i], seq_clr[i]) : flags[i];
    if (i < NUM_TMR) begin : g_tmr
      assign after_tmr[i] = !tmr_en    ? after_seq[i] :
                            tmr_set[i] ? 1'b1 :
                            tmr_clr[i] ? 1'b0 : after_seq[i];
    end else begin : g_notmr
      assign after_tmr[i] = after_seq[i];
    end
    assign nxt[i] = host_en ? mask_update(after_tmr[i], host_set[i], host_clr[i]) : after_tmr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  AST_TMR_SPARES_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && !seq_en && !host_en) |=> $stable(flags[NUM_GP-1:NUM_TMR])); // R4
  AST_HOST_SET_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |=> ((flags & $past(host_set & ~host_clr)) == $past(host_set & ~host_clr))); // R5
  AST_HOST_CLR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |=> ((flags & $past(host_clr & ~host_set)) == '0)); // R2
  AST_FLG_SET_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !tmr_en && !host_en) |=>
      ((flags & $past(seq_set & ~seq_clr)) == $past(seq_set & ~seq_clr))); // R3
endmodule

// File: rtl/msg_result_reg.sv
module msg_result_reg #(
  parameter int NUM_MSG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NUM_MSG-1:0] result,
  output logic [NUM_MSG-1:0] codes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    codes <= '0;
    else if (load) codes <= result;
  end

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(codes)); // R6
  AST_MSG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (codes == $past(result))); // R6
endmodule

// File: rtl/cond_select.sv
module cond_select #(
  parameter int NUM_CODES = 16,
  parameter int SEL_W     = $clog2(NUM_CODES)
) (
  input  logic [NUM_CODES-1:0] codes,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 invert,
  output logic                 hit
);
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_CODES; k++)
      if (sel == SEL_W'(k)) hit = codes[k];
    hit = hit ^ invert;
  end
endmodule

// File: rtl/cond_flag_bank.sv
module cond_flag_bank #(
  parameter int NUM_GP    = 8,
  parameter int NUM_MSG   = 8,
  parameter int NUM_TMR   = 2,
  localparam int NUM_CODES = NUM_GP + NUM_MSG,
  localparam int SEL_W     = $clog2(NUM_CODES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr_en,
  input  logic [NUM_GP-1:0]    host_set_mask,
  input  logic [NUM_GP-1:0]    host_clr_mask,
  input  logic                 flg_en,
  input  logic [2*NUM_GP-1:0]  flg_param,
  input  logic                 tcmp_en,
  input  logic [NUM_TMR-1:0]   tcmp_set,
  input  logic [NUM_TMR-1:0]   tcmp_clr,
  input  logic                 msg_done,
  input  logic [NUM_MSG-1:0]   msg_result,
  input  logic [SEL_W-1:0]     cond_sel,
  input  logic                 cond_invert,
  output logic                 cond_true,
  output logic [NUM_CODES-1:0] cond_codes
);
  logic [NUM_GP-1:0]  gp_q;
  logic [NUM_MSG-1:0] msg_q;

  gp_flag_reg #(.NUM_GP(NUM_GP), .NUM_TMR(NUM_TMR)) u_gp (
    .clk(clk), .rst_n(rst_n),
    .seq_en(flg_en), .seq_set(flg_param[2*NUM_GP-1:NUM_GP]), .seq_clr(flg_param[NUM_GP-1:0]),
    .tmr_en(tcmp_en), .tmr_set(tcmp_set), .tmr_clr(tcmp_clr),
    .host_en(host_wr_en), .host_set(host_set_mask), .host_clr(host_clr_mask),
    .flags(gp_q)
  );

  msg_result_reg #(.NUM_MSG(NUM_MSG)) u_msg (
    .clk(clk), .rst_n(rst_n), .load(msg_done), .result(msg_result), .codes(msg_q)
  );

  assign cond_codes = {msg_q, gp_q};

  cond_select #(.NUM_CODES(NUM_CODES), .SEL_W(SEL_W)) u_sel (
    .codes(cond_codes), .sel(cond_sel), .invert(cond_invert), .hit(cond_true)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (cond_codes == '0)); // R1
  AST_GP_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr_en && !flg_en && !tcmp_en) |=> $stable(cond_codes[NUM_GP-1:0])); // R9
  AST_MSG_UNTOUCHED_BY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_done |=> $stable(cond_codes[NUM_CODES-1:NUM_GP])); // R9
endmodule

// File: tb/cond_flag_bank_tb_top.sv
module cond_flag_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr_en = 1'b0;
  logic [7:0] host_set_mask = '0, host_clr_mask = '0;
  logic flg_en = 1'b0;
  logic [15:0] flg_param = '0;
  logic tcmp_en = 1'b0;
  logic [1:0] tcmp_set = '0, tcmp_clr = '0;
  logic msg_done = 1'b0;
  logic [7:0] msg_result = '0;
  logic [3:0] cond_sel = '0;
  logic cond_invert = 1'b0;
  logic cond_true;
  logic [15:0] cond_codes;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_gp = '0, exp_msg = '0;

  always #5 clk = ~clk;

  cond_flag_bank dut_i (.*);

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sc(input logic [7:0] cur, input logic [7:0] s, input logic [7:0] c);
    return (cur & ~s & ~c) | (s & ~c) | (~cur & s & c);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    host_wr_en = 0; flg_en = 0; tcmp_en = 0; msg_done = 0;
  endtask

  task automatic host_wr(input logic [7:0] s, input logic [7:0] c);
    host_wr_en = 1; host_set_mask = s; host_clr_mask = c; tick();
    exp_gp = sc(exp_gp, s, c);
  endtask

  task automatic flg_wr(input logic [7:0] s, input logic [7:0] c);
    flg_en = 1; flg_param = {s, c}; tick();
    exp_gp = sc(exp_gp, s, c);
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (2) @(posedge clk); #1;
    check("R1 reset", cond_codes, 16'h0000);
    rst_n = 1; tick();
    check("R1 after release", cond_codes, 16'h0000);
    cond_sel = 4'd9; cond_invert = 1; #1;
    check("R8 inverted zero", {15'd0, cond_true}, 16'd1);
    cond_invert = 0;
  endtask

  task automatic t_host();
    host_wr(8'hA5, 8'h00); check("R2 set", cond_codes, {exp_msg, 8'hA5});
    host_wr(8'h00, 8'h05); check("R2 clear", cond_codes, {exp_msg, 8'hA0});
    host_wr(8'hF0, 8'hF0); check("R2 toggle", cond_codes, {exp_msg, 8'h50});
    host_wr(8'h00, 8'h00); check("R2 empty masks hold", cond_codes, {exp_msg, 8'h50});
    host_set_mask = 8'hFF; tick();
    check("R7 no strobe no change", cond_codes, {exp_msg, 8'h50});
  endtask

  task automatic t_flg();
    flg_wr(8'h0F, 8'h00); check("R3 set byte", cond_codes, {exp_msg, 8'h5F});
    flg_wr(8'h00, 8'h50); check("R3 clear byte", cond_codes, {exp_msg, 8'h0F});
    flg_wr(8'h03, 8'h03); check("R3 both toggle", cond_codes, {exp_msg, 8'h0C});
  endtask

  task automatic t_tmr();
    tcmp_en = 1; tcmp_set = 2'b01; tcmp_clr = 2'b00; tick();
    check("R4 set GP0", cond_codes, {exp_msg, 8'h0D});
    tcmp_en = 1; tcmp_set = 2'b00; tcmp_clr = 2'b01; tick();
    check("R4 clear GP0", cond_codes, {exp_msg, 8'h0C});
    tcmp_en = 1; tcmp_set = 2'b10; tcmp_clr = 2'b10; tick();
    check("R4 set priority GP1", cond_codes, {exp_msg, 8'h0E});
    tcmp_en = 1; tcmp_set = 2'b00; tcmp_clr = 2'b11; tick();
    check("R4 upper flags untouched", cond_codes, {exp_msg, 8'h0C});
    exp_gp = 8'h0C;
  endtask

  task automatic t_order();
    // GP0: instr clears, timer sets -> 1. GP1: timer sets, host clears -> 0.
    // GP7: instr sets, host clears -> 0. GP6: instr sets, host toggles -> 0.
    flg_en = 1; flg_param = {8'hC0, 8'h01};
    tcmp_en = 1; tcmp_set = 2'b11; tcmp_clr = 2'b00;
    host_wr_en = 1; host_set_mask = 8'h40; host_clr_mask = 8'hC2;
    tick();
    check("R5 three writers", cond_codes, {exp_msg, 8'h0D});
    exp_gp = 8'h0D;
  endtask

  task automatic t_msg();
    msg_result = 8'h3C; msg_done = 1; tick(); exp_msg = 8'h3C;
    check("R6 load", cond_codes, {8'h3C, exp_gp});
    msg_result = 8'hC3; tick();
    check("R6 hold without strobe", cond_codes, {8'h3C, exp_gp});
    host_wr(8'hFF, 8'h00);
    check("R9 flag write spares msg codes", cond_codes, {8'h3C, 8'hFF});
    msg_result = 8'h81; msg_done = 1; tick(); exp_msg = 8'h81;
    check("R9 msg_done spares flags", cond_codes, {8'h81, 8'hFF});
  endtask

  task automatic t_sel();
    host_wr(8'h00, 8'hAA);
    for (int k = 0; k < 16; k++) begin
      for (int v = 0; v < 2; v++) begin
        logic [15:0] all;
        cond_sel = 4'(k); cond_invert = v[0]; #1;
        all = {exp_msg, exp_gp};
        check("R8 select", {15'd0, cond_true}, {15'd0, all[k] ^ v[0]});
      end
    end
  endtask

  initial begin
    t_reset();
    t_host();
    t_flg();
    t_tmr();
    t_order();
    t_msg();
    t_sel();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule